// File: doc/BRIEF.md
# Multiplexed Expansion Bus Flash Controller

This block lets host software read and write a byte-wide Flash or EPROM of up to 1 MB through a narrow expansion bus, one byte per host request. Software programs a 4-bit upper address field and an access enable, then a 16-bit lower address. After that, each read or write of the data-port register runs exactly one bus cycle. Every bus cycle runs on the host clock.

The 20-bit address leaves the block in two steps. In the first clock the top nibble, zero-extended to a byte, sits on the shared address lane. A rising address strobe lets an external edge-triggered latch capture it. In the next clock the middle address byte moves to a second lane and the low byte replaces the top byte on the shared lane. Chip select then opens, with output enable for a read or write enable for a write, for a programmable number of clocks. Data moves on its own byte lane. A busy flag covers the whole cycle. A request made while busy is dropped and raises a sticky error.

Top module: `xbus_flash_ctrl`

## Requirements
- R1: After a synchronous reset the controller is idle: `busy`=0, `xfer_err`=0, `rd_done`=0, `rd_byte`=0, `eb_cs_n`=1, `eb_we_n`=1, `eb_as_oe_n`=0, `eb_dq_oe`=0, both address lanes 0, the enable is 0, the address fields are 0 and the wait field is 4.
- R2: The register selector picks one of four registers. Selector 0 is the upper register: bit 15 is the enable and bits 3:0 are the upper address. Selector 1 is the lower address. Selector 2 is the data port, which reads back `{8'h00, rd_byte}`. Selector 3 is control: bits 3:0 are the wait count, bit 14 the error and bit 15 busy. Writing selector 3 with bit 14 set clears the error. Unused bits read 0.
- R3: A data-port read or write made while the enable is 0 starts no cycle and sets no error.
- R4: In the first clock after an accepted request, `eb_as_oe_n`=1 and `eb_ua`={4'b0, upper[3:0]}. The strobes stay released and `eb_mid`=0.
- R5: In the second clock, `eb_mid`=lower[15:8] and `eb_ua`=lower[7:0]. `eb_as_oe_n` is 0 for a read and 1 for a write, and chip select stays released. Both lanes hold these values through the strobe phase.
- R6: A read holds `eb_cs_n`=0, `eb_as_oe_n`=0 and `eb_dq_oe`=0 for N clocks, where N is the wait field and a field of 0 counts as 1. The data is sampled at the end of the last of these clocks into `rd_byte`, and `rd_done` pulses in the following clock.
- R7: A write holds `eb_cs_n`=0, `eb_we_n`=0, `eb_as_oe_n`=1 and `eb_dq_oe`=1 for N clocks, with `eb_dq_out` equal to bits 7:0 of the data written to the data port.
- R8: `busy` is 1 from the clock after the accepting edge until the strobes are released, which is 2+N clocks in all.
- R9: A data-port request sampled while `busy` is 1 is ignored and sets `xfer_err`. The error stays set until it is cleared through selector 3.
- R10: If a read and a write of the data port arrive in the same clock, a write cycle runs.
- R11: The address, write data and wait count are captured when a request is accepted. Register writes made during a cycle do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all bus cycles run on it |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register selector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (starts a cycle on the data port) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the selected register |
| busy | output | 1 | Bus cycle in progress |
| xfer_err | output | 1 | Sticky error: request made while busy |
| rd_done | output | 1 | One-clock pulse: `rd_byte` holds new read data |
| rd_byte | output | 8 | Last byte read from the device |
| eb_ua | output | 8 | Shared lane: top address byte, then low address byte |
| eb_mid | output | 8 | Middle address byte lane |
| eb_as_oe_n | output | 1 | Address strobe (rising edge) and active-low output enable |
| eb_cs_n | output | 1 | Device chip select, active low |
| eb_we_n | output | 1 | Device write enable, active low |
| eb_dq_out | output | 8 | Write data lane |
| eb_dq_oe | output | 1 | Drive enable for the data lane |
| eb_dq_in | input | 8 | Read data lane from the device |

## Verification
Two events can land on the same clock edge: the end of a bus cycle and a new data-port request. The bench times a read request to be sampled exactly on the edge that ends a cycle, where `busy` is still 1, so it must be dropped and must set the error. It then holds the request one more clock, into the `rd_done` clock, where it must be accepted. A read and a write of the data port in the same clock, and a lower-address write during the address phase, are judged by comparing every lane, strobe and register readback on every clock against a behavioural model.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int UP_W     = 4;
    localparam int LO_W     = 16;
    localparam int ADDR_W   = UP_W + LO_W;
    localparam int BYTE_W   = 8;
    localparam int REG_W    = 16;
    localparam int WAIT_W   = 4;
    localparam int SEL_W    = 2;

    localparam logic [SEL_W-1:0] SEL_UPPER = 2'd0;
    localparam logic [SEL_W-1:0] SEL_LOWER = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd3;

    localparam int EN_BIT   = 15;
    localparam int BUSY_BIT = 15;
    localparam int ERR_BIT  = 14;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ADDR_HI = 2'd1,
        PH_ADDR_LO = 2'd2,
        PH_STROBE  = 2'd3
    } phase_t;

    // one accepted bus cycle, frozen at acceptance
    typedef struct packed {
        logic              is_write;
        logic [UP_W-1:0]   up;
        logic [LO_W-1:0]   lo;
        logic [BYTE_W-1:0] wdata;
        logic [WAIT_W-1:0] waits;
    } xfer_t;

    // everything driven onto the expansion bus
    typedef struct packed {
        logic [BYTE_W-1:0] ua;
        logic [BYTE_W-1:0] mid;
        logic              as_oe_n;
        logic              cs_n;
        logic              we_n;
        logic              dq_oe;
        logic [BYTE_W-1:0] dq;
    } pins_t;

    function automatic logic [WAIT_W-1:0] eff_waits(input logic [WAIT_W-1:0] w);
        return (w == '0) ? WAIT_W'(1) : w;
    endfunction
endpackage

// File: rtl/xfc_regs.sv
module xfc_regs
    import xfc_pkg::*;
#(
    parameter int unsigned WAIT_RST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                busy,
    input  logic [BYTE_W-1:0]   rd_byte,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                start,
    output xfer_t               xfer,
    output logic                err
);
    logic              enable_q;
    logic [UP_W-1:0]   up_q;
    logic [LO_W-1:0]   lo_q;
    logic [WAIT_W-1:0] waits_q;
    logic              dp_hit;
    logic              reject;
    logic              err_clr;

    assign dp_hit  = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
    assign start   = dp_hit && enable_q && !busy;
    assign reject  = dp_hit && busy;
    assign err_clr = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            up_q     <= '0;
            lo_q     <= '0;
            waits_q  <= WAIT_W'(WAIT_RST);
            err      <= 1'b0;
            xfer     <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_UPPER: begin
                        enable_q <= reg_wdata[EN_BIT];
                        up_q     <= reg_wdata[UP_W-1:0];
                    end
                    SEL_LOWER: lo_q    <= reg_wdata[LO_W-1:0];
                    SEL_CTRL:  waits_q <= reg_wdata[WAIT_W-1:0];
                    default: ;
                endcase
            end
            if (reject) begin
                err <= 1'b1;
            end else if (err_clr) begin
                err <= 1'b0;
            end
            if (start) begin
                xfer.is_write <= reg_wr;
                xfer.up       <= up_q;
                xfer.lo       <= lo_q;
                xfer.wdata    <= reg_wdata[BYTE_W-1:0];
                xfer.waits    <= eff_waits(waits_q);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_UPPER: begin
                reg_rdata[EN_BIT]     = enable_q;
                reg_rdata[UP_W-1:0]   = up_q;
            end
            SEL_LOWER: reg_rdata[LO_W-1:0]   = lo_q;
            SEL_DATA:  reg_rdata[BYTE_W-1:0] = rd_byte;
            SEL_CTRL: begin
                reg_rdata[BUSY_BIT]     = busy;
                reg_rdata[ERR_BIT]      = err;
                reg_rdata[WAIT_W-1:0]   = waits_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
    import xfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                is_write,
    input  logic [WAIT_W-1:0]   waits,
    input  logic [BYTE_W-1:0]   dq_in,
    output phase_t              phase,
    output logic                busy,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                rd_done
);
    logic [WAIT_W-1:0] cnt_q;

    assign busy = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt_q   <= '0;
            rd_byte <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) phase <= PH_ADDR_HI;
                end
                PH_ADDR_HI: phase <= PH_ADDR_LO;
                PH_ADDR_LO: begin
                    phase <= PH_STROBE;
                    cnt_q <= waits - WAIT_W'(1);
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        phase <= PH_IDLE;
                        if (!is_write) begin
                            rd_byte <= dq_in;
                            rd_done <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - WAIT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfc_lanes.sv
module xfc_lanes
    import xfc_pkg::*;
(
    input  phase_t              phase,
    input  logic                is_write,
    input  logic [UP_W-1:0]     up,
    input  logic [LO_W-1:0]     lo,
    input  logic [BYTE_W-1:0]   wdata,
    output pins_t               pins
);
    localparam int PAD_W = BYTE_W - UP_W;

    always_comb begin
        pins         = '0;
        pins.cs_n    = 1'b1;
        pins.we_n    = 1'b1;
        pins.as_oe_n = 1'b0;
        unique case (phase)
            PH_ADDR_HI: begin
                pins.as_oe_n = 1'b1;
                pins.ua      = {{PAD_W{1'b0}}, up};
            end
            PH_ADDR_LO: begin
                pins.as_oe_n = is_write;
                pins.ua      = lo[BYTE_W-1:0];
                pins.mid     = lo[LO_W-1:BYTE_W];
            end
            PH_STROBE: begin
                pins.as_oe_n = is_write;
                pins.ua      = lo[BYTE_W-1:0];
                pins.mid     = lo[LO_W-1:BYTE_W];
                pins.cs_n    = 1'b0;
                pins.we_n    = !is_write;
                pins.dq_oe   = is_write;
                pins.dq      = is_write ? wdata : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbus_flash_ctrl.sv
module xbus_flash_ctrl
    import xfc_pkg::*;
#(
    parameter int unsigned WAIT_RST = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          busy,
    output logic          xfer_err,
    output logic          rd_done,
    output logic [7:0]    rd_byte,
    output logic [7:0]    eb_ua,
    output logic [7:0]    eb_mid,
    output logic          eb_as_oe_n,
    output logic          eb_cs_n,
    output logic          eb_we_n,
    output logic [7:0]    eb_dq_out,
    output logic          eb_dq_oe,
    input  logic [7:0]    eb_dq_in
);
    logic   start;
    xfer_t  xfer;
    phase_t phase;
    pins_t  pins;

    xfc_regs #(.WAIT_RST(WAIT_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .rd_byte   (rd_byte),
        .reg_rdata (reg_rdata),
        .start     (start),
        .xfer      (xfer),
        .err       (xfer_err)
    );

    xfc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_write (xfer.is_write),
        .waits    (xfer.waits),
        .dq_in    (eb_dq_in),
        .phase    (phase),
        .busy     (busy),
        .rd_byte  (rd_byte),
        .rd_done  (rd_done)
    );

    xfc_lanes u_lanes (
        .phase    (phase),
        .is_write (xfer.is_write),
        .up       (xfer.up),
        .lo       (xfer.lo),
        .wdata    (xfer.wdata),
        .pins     (pins)
    );

    assign eb_ua      = pins.ua;
    assign eb_mid     = pins.mid;
    assign eb_as_oe_n = pins.as_oe_n;
    assign eb_cs_n    = pins.cs_n;
    assign eb_we_n    = pins.we_n;
    assign eb_dq_oe   = pins.dq_oe;
    assign eb_dq_out  = pins.dq;
endmodule

// File: rtl/xfc_chk.sv
module xfc_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr_req,
    input logic       busy,
    input logic       xfer_err,
    input logic       rd_done,
    input logic [7:0] eb_mid,
    input logic       eb_as_oe_n,
    input logic       eb_cs_n,
    input logic       eb_we_n,
    input logic       eb_dq_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !xfer_err && !rd_done && eb_cs_n && eb_we_n && !eb_dq_oe));

    assert_latch_phase_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(eb_as_oe_n) |-> (eb_cs_n && eb_we_n && eb_mid == 8'h00));

    assert_read_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (!eb_cs_n && eb_we_n) |-> (!eb_as_oe_n && !eb_dq_oe));

    assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> (!busy && $past(!eb_cs_n)));

    assert_write_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !eb_we_n |-> (!eb_cs_n && eb_dq_oe && eb_as_oe_n));

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !eb_cs_n |-> busy);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_err && !clr_req) |=> xfer_err);
endmodule

bind xbus_flash_ctrl xfc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_req    (reg_wr && (reg_sel == 2'd3) && reg_wdata[14]),
    .busy       (busy),
    .xfer_err   (xfer_err),
    .rd_done    (rd_done),
    .eb_mid     (eb_mid),
    .eb_as_oe_n (eb_as_oe_n),
    .eb_cs_n    (eb_cs_n),
    .eb_we_n    (eb_we_n),
    .eb_dq_oe   (eb_dq_oe)
);

// File: tb/xbus_flash_ctrl_tb.sv
module xbus_flash_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        busy, xfer_err, rd_done;
    logic [7:0]  rd_byte, eb_ua, eb_mid, eb_dq_out;
    logic        eb_as_oe_n, eb_cs_n, eb_we_n, eb_dq_oe;
    logic [7:0]  eb_dq_in = 8'h00;

    always #10 clk = ~clk;   // 50 MHz

    xbus_flash_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .xfer_err(xfer_err),
        .rd_done(rd_done), .rd_byte(rd_byte), .eb_ua(eb_ua), .eb_mid(eb_mid),
        .eb_as_oe_n(eb_as_oe_n), .eb_cs_n(eb_cs_n), .eb_we_n(eb_we_n),
        .eb_dq_out(eb_dq_out), .eb_dq_oe(eb_dq_oe), .eb_dq_in(eb_dq_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ROM image: signature bytes at offsets 0 and 1, a pattern elsewhere
    function automatic logic [7:0] img(input int a);
        if (a == 0) return 8'h55;
        if (a == 1) return 8'hAA;
        return 8'((a * 13) + (a >> 8));
    endfunction

    // ---------------- device side: external latch + memory ----------------
    logic [7:0] lat_q = 8'h00;
    logic [7:0] dev_mem [int];

    always @(posedge eb_as_oe_n) lat_q <= eb_ua;

    function automatic logic [7:0] dev_rd(input int a);
        if (dev_mem.exists(a)) return dev_mem[a];
        return img(a);
    endfunction

    always @(posedge clk) begin
        if (!eb_cs_n && !eb_we_n)
            dev_mem[int'({lat_q[3:0], eb_mid, eb_ua})] = eb_dq_out;
    end

    always @(negedge clk) begin
        if (!eb_cs_n && !eb_as_oe_n && eb_we_n)
            eb_dq_in <= dev_rd(int'({lat_q[3:0], eb_mid, eb_ua}));
        else
            eb_dq_in <= 8'h00;
    end

    // ---------------- behavioural reference model ----------------
    logic        m_en, m_wr, m_err, m_done, m_dp, m_was_busy;
    logic [3:0]  m_up, m_wait;
    logic [15:0] m_lo;
    logic [19:0] m_addr;
    logic [7:0]  m_data, m_rdbyte;
    int          m_pos, m_n;
    logic [7:0]  m_mem [int];

    function automatic logic [7:0] mdl_rd(input int a);
        if (m_mem.exists(a)) return m_mem[a];
        return img(a);
    endfunction

    always @(posedge clk) begin
        m_dp   = (reg_wr || reg_rd) && (reg_sel == 2'd2);
        m_done = 1'b0;
        if (rst) begin
            m_en = 0; m_wr = 0; m_err = 0; m_up = 0; m_lo = 0; m_wait = 4;
            m_addr = 0; m_data = 0; m_rdbyte = 0; m_pos = 0; m_n = 1;
        end else begin
            m_was_busy = (m_pos != 0);
            if (m_pos != 0) begin
                if (m_pos == 2 + m_n) begin
                    if (m_wr) m_mem[int'(m_addr)] = m_data;
                    else begin m_rdbyte = mdl_rd(int'(m_addr)); m_done = 1'b1; end
                    m_pos = 0;
                end else begin
                    m_pos++;
                end
            end
            if (m_dp && m_was_busy) m_err = 1'b1;
            else if (reg_wr && reg_sel == 2'd3 && reg_wdata[14]) m_err = 1'b0;
            if (m_dp && !m_was_busy && m_en) begin
                m_pos  = 1;
                m_wr   = reg_wr;
                m_addr = {m_up, m_lo};
                m_data = reg_wdata[7:0];
                m_n    = (m_wait == 0) ? 1 : int'(m_wait);
            end
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: begin m_en = reg_wdata[15]; m_up = reg_wdata[3:0]; end
                    2'd1: m_lo = reg_wdata;
                    2'd3: m_wait = reg_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    // compare every clock, 5 ns after the edge
    always @(posedge clk) begin
        logic [7:0]  e_ua, e_mid, e_dq;
        logic        e_as, e_cs, e_we, e_oe, e_busy;
        logic [15:0] e_rd;
        string       tag;
        #5;
        e_ua = 0; e_mid = 0; e_dq = 0; e_as = 0; e_cs = 1; e_we = 1; e_oe = 0; tag = "R1";
        if (m_pos == 1) begin
            tag = "R4"; e_as = 1; e_ua = {4'h0, m_addr[19:16]};
        end else if (m_pos >= 2) begin
            tag = (m_pos == 2) ? "R5" : (m_wr ? "R7" : "R6");
            e_as = m_wr; e_ua = m_addr[7:0]; e_mid = m_addr[15:8];
            if (m_pos >= 3) begin
                e_cs = 0; e_we = !m_wr; e_oe = m_wr; e_dq = m_wr ? m_data : 8'h00;
            end
        end
        e_busy = (m_pos != 0);
        case (reg_sel)
            2'd0: e_rd = {m_en, 11'h0, m_up};
            2'd1: e_rd = m_lo;
            2'd2: e_rd = {8'h00, m_rdbyte};
            default: e_rd = {e_busy, m_err, 10'h0, m_wait};
        endcase
        chk(tag, "eb_ua", 32'(eb_ua), 32'(e_ua));
        chk(tag, "eb_mid", 32'(eb_mid), 32'(e_mid));
        chk(tag, "eb_as_oe_n", 32'(eb_as_oe_n), 32'(e_as));
        chk(tag, "eb_cs_n", 32'(eb_cs_n), 32'(e_cs));
        chk(tag, "eb_we_n", 32'(eb_we_n), 32'(e_we));
        chk(tag, "eb_dq_oe", 32'(eb_dq_oe), 32'(e_oe));
        chk(tag, "eb_dq_out", 32'(eb_dq_out), 32'(e_dq));
        chk("R8", "busy", 32'(busy), 32'(e_busy));
        chk("R9", "xfer_err", 32'(xfer_err), 32'(m_err));
        chk("R6", "rd_done", 32'(rd_done), 32'(m_done));
        chk("R6", "rd_byte", 32'(rd_byte), 32'(m_rdbyte));
        chk("R2", "reg_rdata", 32'(reg_rdata), 32'(e_rd));
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 30000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic dp_read();
        @(negedge clk); reg_sel = 2'd2; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic dp_write(input logic [7:0] d);
        @(negedge clk); reg_sel = 2'd2; reg_wdata = {8'h00, d}; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_at(input logic [3:0] up, input logic [15:0] lo);
        wr_reg(2'd0, {1'b1, 11'h0, up});
        wr_reg(2'd1, lo);
        dp_read();
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: register readback, enable still off
        wr_reg(2'd0, 16'h0007);
        reg_sel = 2'd0; @(negedge clk);
        chk("R2", "upper readback", 32'(reg_rdata), 32'h0007);

        // R3: data port ignored while disabled
        dp_read();
        dp_write(8'h11);
        chk("R3", "busy while disabled", 32'(busy), 32'h0);
        chk("R3", "err while disabled", 32'(xfer_err), 32'h0);

        // ROM signature at offsets 0 and 1, default wait of 4
        read_at(4'h0, 16'h0000);
        chk("R6", "signature byte 0", 32'(rd_byte), 32'h55);
        read_at(4'h0, 16'h0001);
        chk("R6", "signature byte 1", 32'(rd_byte), 32'hAA);

        // short and zero wait counts, full 20-bit address
        wr_reg(2'd3, 16'h0001);
        read_at(4'hA, 16'h3C5E);
        wr_reg(2'd3, 16'h0000);
        read_at(4'hF, 16'hFFFF);
        wr_reg(2'd3, 16'h000F);
        read_at(4'h5, 16'h00A7);

        // R7: write then read back
        wr_reg(2'd3, 16'h0002);
        wr_reg(2'd0, 16'h8001);
        wr_reg(2'd1, 16'h2345);
        dp_write(8'h5A);
        wait_idle();
        read_at(4'h1, 16'h2345);
        chk("R7", "written byte", 32'(rd_byte), 32'h5A);

        // R10: read and write together make a write
        wr_reg(2'd1, 16'h0102);
        @(negedge clk); reg_sel = 2'd2; reg_wdata = 16'h00C3; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "we_n in strobe", 32'(eb_we_n), 32'h0);
        wait_idle();
        read_at(4'h1, 16'h0102);
        chk("R10", "combined access wrote", 32'(rd_byte), 32'hC3);

        // R11: lower register rewritten during the address phase
        wr_reg(2'd3, 16'h0003);
        wr_reg(2'd1, 16'h1234);
        @(negedge clk); reg_sel = 2'd2; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; reg_sel = 2'd1; reg_wdata = 16'hBEEF; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R11", "mid lane kept", 32'(eb_mid), 32'h12);
        chk("R11", "low lane kept", 32'(eb_ua), 32'h34);
        wait_idle();

        // R9: request while busy, then clear
        wr_reg(2'd3, 16'h0004);
        dp_read();
        dp_write(8'h77);
        chk("R9", "error after busy request", 32'(xfer_err), 32'h1);
        wait_idle();
        chk("R9", "error still set", 32'(xfer_err), 32'h1);
        wr_reg(2'd3, 16'h4004);
        chk("R9", "error cleared", 32'(xfer_err), 32'h0);

        // R9/R8: request on the completing edge is dropped, one clock later accepted
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd0, 16'h8000);
        @(negedge clk); reg_sel = 2'd2; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        repeat (5) @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        chk("R9", "completing-edge request rejected", 32'(xfer_err), 32'h1);
        chk("R6", "done in same clock", 32'(rd_done), 32'h1);
        @(negedge clk); reg_rd = 1'b0;
        chk("R8", "next request accepted", 32'(busy), 32'h1);
        wait_idle();
        chk("R6", "second read byte", 32'(rd_byte), 32'h55);

        // R1: reset mid-cycle returns to idle
        dp_read();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "busy after reset", 32'(busy), 32'h0);
        chk("R1", "cs_n after reset", 32'(eb_cs_n), 32'h1);
        reg_sel = 2'd3; @(negedge clk);
        chk("R1", "ctrl after reset", 32'(reg_rdata), 32'h0004);
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule